// File: doc/BRIEF.md
# Configuration Image Header Detector

This block decides whether a flash region holds a usable FPGA configuration image. A flash reader streams the leading bytes of the region into it. The block searches those bytes for the two-byte synchronisation marker that every configuration image carries after its padding. Boot logic then reads the verdict and chooses which image to load.

A scan begins with a one-cycle `scan_start` pulse. The block takes bytes only in cycles where `byte_valid` is high. It stops at the first marker or after a fixed number of bytes, whichever comes first. It then raises `scan_done` for one cycle and holds the verdict on `hdr_ok` until the next scan begins. Runs of 0xFF padding before the marker are passed over without effect, so the marker may sit at any depth inside the window.

Top module: `bitstream_hdr_check`

## Requirements
- R1: After reset, `hdr_ok`, `scan_done` and `scan_busy` are all 0.
- R2: A `scan_start` pulse sets `scan_busy` in the next cycle and clears `hdr_ok`. Bytes that arrive while no scan is active are ignored and never produce `scan_done`.
- R3: A byte 0xAA followed by the very next accepted byte 0x99 ends the scan. In the cycle after the 0x99 byte is accepted, `scan_done` is 1 and `hdr_ok` is 1.
- R4: Leading 0xFF padding bytes are skipped, so a marker that follows any number of them inside the window is still found.
- R5: An 0xAA that is not followed by 0x99 does not end the scan, and the next byte is tested again as a possible 0xAA (AA AA 99 matches). A byte between 0xAA and 0x99, such as 0xFF, breaks the pair.
- R6: The window is WINDOW_BYTES (default 64) accepted bytes, numbered from 0. The marker matches when its 0xAA is at offset 62 and its 0x99 at offset 63. An 0xAA at offset 63 cannot match: the scan ends after that byte with `hdr_ok` = 0.
- R7: If no marker appears among the 64 bytes, `scan_done` pulses in the cycle after byte 63 and `hdr_ok` is 0.
- R8: `scan_done` lasts one cycle and fires exactly once per scan. Bytes that follow a match or the end of the window are ignored.
- R9: `hdr_ok` holds its value from the end of a scan until the next `scan_start`.
- R10: Cycles with `byte_valid` low neither count toward the window nor break a marker pair.
- R11: A `scan_start` during an active scan restarts it. The byte count and any pending 0xAA are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_start | input | 1 | One-cycle pulse that begins a scan |
| byte_valid | input | 1 | `byte_data` carries a byte this cycle |
| byte_data | input | 8 | Image byte, in flash order |
| scan_busy | output | 1 | A scan is in progress |
| scan_done | output | 1 | One-cycle pulse at the end of a scan |
| hdr_ok | output | 1 | Verdict of the last scan: 1 when the marker was found |

## Verification
The assertions assume that `scan_start` and `byte_valid` are never high in the same cycle. The block gives the start priority and drops that byte, and the properties about which cycles a done pulse may follow are written on that basis. Every bench task releases the start pulse before it presents the first byte, and drives all inputs on the falling edge. Bytes are also pushed after a scan finishes and while the block is idle, to show that they have no effect.

// File: rtl/hdr_scan_pkg.sv
package hdr_scan_pkg;
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;
endpackage

// File: rtl/hdr_win_counter.sv
// Counts bytes accepted in the current scan and flags the final window slot.
module hdr_win_counter #(
  parameter int WINDOW_BYTES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic last_slot
);
  localparam int CNT_W = (WINDOW_BYTES > 1) ? $clog2(WINDOW_BYTES) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WINDOW_BYTES - 1);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count_q <= '0;
    end else if (step && (count_q != LAST_IDX)) begin
      count_q <= count_q + 1'b1;
    end
  end

  // High when the byte now presented occupies the last slot of the window.
  assign last_slot = (count_q == LAST_IDX);
endmodule

// File: rtl/hdr_sync_det.sv
// Detects the two-byte marker across consecutive accepted bytes.
module hdr_sync_det #(
  parameter int              DATA_W  = 8,
  parameter logic [DATA_W-1:0] SYNC_HI = 8'hAA,
  parameter logic [DATA_W-1:0] SYNC_LO = 8'h99
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              step,
  input  logic [DATA_W-1:0] data,
  output logic              pair_hit
);
  logic hi_seen_q;

  // Every accepted byte re-evaluates the first half, so padding or any other
  // byte that is not the first half drops a pending match.
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      hi_seen_q <= 1'b0;
    end else if (step) begin
      hi_seen_q <= (data == SYNC_HI);
    end
  end

  assign pair_hit = step && hi_seen_q && (data == SYNC_LO);
endmodule

// File: rtl/hdr_scan_ctrl.sv
// Scan sequencing and registered verdict.
module hdr_scan_ctrl
  import hdr_scan_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic step,
  input  logic pair_hit,
  input  logic last_slot,
  output logic busy,
  output logic done,
  output logic found
);
  scan_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SCAN_IDLE;
      done    <= 1'b0;
      found   <= 1'b0;
    end else if (start) begin
      state_q <= SCAN_RUN;
      done    <= 1'b0;
      found   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state_q == SCAN_RUN && step) begin
        if (pair_hit) begin
          state_q <= SCAN_IDLE;
          done    <= 1'b1;
          found   <= 1'b1;
        end else if (last_slot) begin
          state_q <= SCAN_IDLE;
          done    <= 1'b1;
          found   <= 1'b0;
        end
      end
    end
  end

  assign busy = (state_q == SCAN_RUN);
endmodule

// File: rtl/bitstream_hdr_check.sv
module bitstream_hdr_check #(
  parameter int                WINDOW_BYTES = 64,
  parameter int                DATA_W       = 8,
  parameter logic [DATA_W-1:0] SYNC_HI      = 8'hAA,
  parameter logic [DATA_W-1:0] SYNC_LO      = 8'h99
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_start,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  output logic              scan_busy,
  output logic              scan_done,
  output logic              hdr_ok
);
  logic step;
  logic pair_hit;
  logic last_slot;

  // A start pulse wins over a byte in the same cycle.
  assign step = byte_valid && scan_busy && !scan_start;

  hdr_win_counter #(
    .WINDOW_BYTES(WINDOW_BYTES)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clear    (scan_start),
    .step     (step),
    .last_slot(last_slot)
  );

  hdr_sync_det #(
    .DATA_W (DATA_W),
    .SYNC_HI(SYNC_HI),
    .SYNC_LO(SYNC_LO)
  ) u_det (
    .clk     (clk),
    .rst     (rst),
    .clear   (scan_start),
    .step    (step),
    .data    (byte_data),
    .pair_hit(pair_hit)
  );

  hdr_scan_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (scan_start),
    .step     (step),
    .pair_hit (pair_hit),
    .last_slot(last_slot),
    .busy     (scan_busy),
    .done     (scan_done),
    .found    (hdr_ok)
  );
endmodule

// File: rtl/hdr_check_sva.sv
module hdr_check_sva (
  input logic clk,
  input logic rst,
  input logic scan_start,
  input logic byte_valid,
  input logic scan_busy,
  input logic scan_done,
  input logic hdr_ok
);
  // R8: the done pulse lasts a single cycle
  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    scan_done |=> !scan_done);

  // R2: a start pulse makes the block busy and clears the verdict
  p_start_arms_r2: assert property (@(posedge clk) disable iff (rst)
    scan_start |=> (scan_busy && !hdr_ok && !scan_done));

  // R2: no scan active and no start means no done next cycle
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (!scan_busy && !scan_start) |=> !scan_done);

  // R9: the verdict changes only at a scan end or after a start
  p_verdict_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(hdr_ok) |-> (scan_done || $past(scan_start)));

  // R3: a done pulse always follows an accepted byte and ends the scan
  p_done_after_byte_r3: assert property (@(posedge clk) disable iff (rst)
    scan_done |-> ($past(byte_valid) && !scan_busy));

  // R1: outputs are quiet in the cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!scan_busy && !scan_done && !hdr_ok));
endmodule

bind bitstream_hdr_check hdr_check_sva u_sva (
  .clk       (clk),
  .rst       (rst),
  .scan_start(scan_start),
  .byte_valid(byte_valid),
  .scan_busy (scan_busy),
  .scan_done (scan_done),
  .hdr_ok    (hdr_ok)
);

// File: tb/bitstream_hdr_check_tb.sv
`timescale 1ns/1ps
module bitstream_hdr_check_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scan_start = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       scan_busy, scan_done, hdr_ok;

  int checks = 0;
  int failures = 0;
  logic [7:0] img [0:79];
  int img_len;

  always #2 clk = ~clk;

  bitstream_hdr_check u_dut (
    .clk(clk), .rst(rst), .scan_start(scan_start), .byte_valid(byte_valid),
    .byte_data(byte_data), .scan_busy(scan_busy), .scan_done(scan_done),
    .hdr_ok(hdr_ok)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    scan_start = 1'b1;
    @(negedge clk);
    scan_start = 1'b0;
  endtask

  // Present one byte for one cycle; on return the reaction is visible.
  task automatic push(input logic [7:0] b);
    byte_valid = 1'b1;
    byte_data  = b;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic fill(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) img[i] = b;
    img_len = n;
  endtask

  // Feed img, record done pulses, then check count, position and verdict.
  task automatic run_scan(input string tag, input int exp_idx, input bit exp_ok);
    int done_cnt = 0;
    int done_idx = -1;
    pulse_start();
    for (int i = 0; i < img_len; i++) begin
      push(img[i]);
      if (scan_done) begin
        done_cnt++;
        if (done_idx < 0) done_idx = i;
      end
    end
    repeat (2) begin
      @(negedge clk);
      if (scan_done) done_cnt++;
    end
    chk(done_cnt == 1, {tag, " R8 done count"}, done_cnt, 1);
    chk(done_idx == exp_idx, {tag, " done position"}, done_idx, exp_idx);
    chk(hdr_ok == exp_ok, {tag, " verdict"}, hdr_ok, exp_ok);
  endtask

  task automatic t_reset();
    chk(!scan_busy && !scan_done && !hdr_ok, "R1 reset outputs", {scan_busy, scan_done, hdr_ok}, 0);
  endtask

  task automatic t_idle_ignored();
    int seen = 0;
    push(8'hAA); if (scan_done) seen++;
    push(8'h99); if (scan_done) seen++;
    chk(seen == 0 && !scan_busy && !hdr_ok, "R2 idle bytes ignored", seen, 0);
    pulse_start();
    chk(scan_busy && !hdr_ok, "R2 start arms", scan_busy, 1);
    fill(8'h00, 64);
    for (int i = 0; i < 64; i++) push(img[i]);
  endtask

  task automatic t_basic();
    fill(8'h00, 12); img[0] = 8'hAA; img[1] = 8'h99;
    run_scan("R3 marker at start", 1, 1'b1);
  endtask

  task automatic t_padding();
    fill(8'hFF, 20); img[10] = 8'hAA; img[11] = 8'h99;
    run_scan("R4 padded marker", 11, 1'b1);
  endtask

  task automatic t_rearm();
    fill(8'h00, 8); img[1] = 8'hAA; img[2] = 8'hAA; img[3] = 8'h99;
    run_scan("R5 AA AA 99", 3, 1'b1);
    fill(8'h00, 64); img[0] = 8'hAA; img[1] = 8'hFF; img[2] = 8'h99;
    run_scan("R5 pad breaks pair", 63, 1'b0);
  endtask

  task automatic t_edge();
    fill(8'hFF, 66); img[62] = 8'hAA; img[63] = 8'h99;
    run_scan("R6 pair ends at 63", 63, 1'b1);
    fill(8'hFF, 66); img[63] = 8'hAA; img[64] = 8'h99;
    run_scan("R6 pair past window", 63, 1'b0);
  endtask

  task automatic t_none();
    fill(8'h55, 70);
    run_scan("R7 no marker", 63, 1'b0);
  endtask

  task automatic t_hold();
    fill(8'hFF, 4); img[2] = 8'hAA; img[3] = 8'h99;
    run_scan("R9 setup", 3, 1'b1);
    repeat (6) @(negedge clk);
    chk(hdr_ok == 1'b1, "R9 verdict held", hdr_ok, 1);
    pulse_start();
    chk(hdr_ok == 1'b0, "R9 start clears verdict", hdr_ok, 0);
    fill(8'h00, 64);
    for (int i = 0; i < 64; i++) push(img[i]);
  endtask

  task automatic t_stall();
    pulse_start();
    push(8'hAA);
    repeat (3) @(negedge clk);
    push(8'h99);
    chk(scan_done && hdr_ok, "R10 gap keeps pair", {scan_done, hdr_ok}, 3);
    pulse_start();
    for (int i = 0; i < 63; i++) begin
      push(8'h00);
      @(negedge clk);
    end
    chk(!scan_done && scan_busy, "R10 gaps not counted", scan_busy, 1);
    push(8'h00);
    chk(scan_done && !hdr_ok, "R10 window ends on byte 63", scan_done, 1);
  endtask

  task automatic t_restart();
    pulse_start();
    for (int i = 0; i < 39; i++) push(8'h00);
    push(8'hAA);
    fill(8'hFF, 64); img[0] = 8'h99; img[62] = 8'hAA; img[63] = 8'h99;
    run_scan("R11 restart", 63, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_idle_ignored();
    t_basic();
    t_padding();
    t_rearm();
    t_edge();
    t_none();
    t_hold();
    t_stall();
    t_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule